// File: doc/BRIEF.md
# Eight-bit ALU with Post-Shifter

This block is the purely combinational arithmetic-logic unit of a small 8-bit processor. It takes a primary operand and a secondary operand. The primary operand is a register or a memory byte. The secondary operand is register A or an immediate. It also takes a 3-bit operation code, a 2-bit post-shift code and the current carry flag. It returns an 8-bit result together with a carry-out and a zero indication.

The main stage computes one of these:
- an add, or an add with carry;
- a subtract that takes away the secondary operand plus the carry;
- a bitwise XOR, OR or AND;
- a pass-through of either operand.

An optional one-bit right shift, logical or arithmetic, is then applied to that value. The block holds no state. The surrounding processor decides whether the flags are latched.

Top module: `alu8_shift`

## Requirements
- R1: With op = 000, result is (primary + secondary) mod 256 and carry_out is bit 8 of the 9-bit sum.
- R2: With op = 001, result is (primary + secondary + carry_in) mod 256 and carry_out is bit 8 of that 9-bit sum.
- R3: With op = 010, result is (primary - (secondary + carry_in)) mod 256 and carry_out is 1 exactly when primary < secondary + carry_in (a borrow).
- R4: With op = 011 the result equals the primary operand; with op = 111 it equals the secondary operand; carry_out is 0 in both cases.
- R5: Ops 100, 101 and 110 give primary XOR, OR and AND secondary respectively, with carry_out 0.
- R6: With shift = 01 the stage-one value is shifted right by one with a 0 entering bit 7, and carry_out becomes the bit shifted out of bit 0.
- R7: With shift = 10 the stage-one value is shifted right by one with bit 7 kept, and carry_out becomes the bit shifted out of bit 0.
- R8: Shift = 11 behaves exactly as shift = 00: result and carry_out are the unshifted values.
- R9: zero_out is 1 exactly when the final 8-bit result, after any shift, is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | Primary operand (register or memory byte) |
| opb | input | 8 | Secondary operand (register A or immediate) |
| op | input | 3 | Operation code |
| shift | input | 2 | Post-shift code: 00 none, 01 logical right, 10 arithmetic right, 11 none |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Final result |
| carry_out | output | 1 | Carry, borrow, or shifted-out bit |
| zero_out | output | 1 | High when result is zero |

## Verification
A fixed list of edge vectors comes first. Sums that wrap exactly to zero separate a correct carry from a dropped bit 8. Subtracts whose secondary operand is 0xFF with the carry set tell borrow-of-sum apart from a subtract that applies the carry alone. Operands with bit 7 set under both shift codes show whether the sign bit is kept or cleared, and whether the outgoing bit 0 replaces the arithmetic carry. A broad pseudo-random sweep then covers every operation code under every shift code, including code 11, against a model built from plain integer arithmetic.

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   op,
  input  logic [1:0]   shift,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         zero_out
);

  localparam logic [2:0] OP_ADD  = 3'b000;
  localparam logic [2:0] OP_ADC  = 3'b001;
  localparam logic [2:0] OP_SBB  = 3'b010;
  localparam logic [2:0] OP_PASA = 3'b011;
  localparam logic [2:0] OP_XOR  = 3'b100;
  localparam logic [2:0] OP_OR   = 3'b101;
  localparam logic [2:0] OP_AND  = 3'b110;
  localparam logic [2:0] OP_PASB = 3'b111;

  localparam logic [1:0] SH_LSR = 2'b01;
  localparam logic [1:0] SH_ASR = 2'b10;

  logic [W:0]   sum_w, sub_w;
  logic [W-1:0] core_v;
  logic         core_c;

  assign sum_w = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, (op == OP_ADC) & carry_in};
  assign sub_w = {1'b0, opa} - ({1'b0, opb} + {{W{1'b0}}, carry_in});

  always_comb begin
    core_c = 1'b0;
    case (op)
      OP_ADD, OP_ADC: {core_c, core_v} = sum_w;
      OP_SBB:         {core_c, core_v} = sub_w;
      OP_PASA:        core_v = opa;
      OP_XOR:         core_v = opa ^ opb;
      OP_OR:          core_v = opa | opb;
      OP_AND:         core_v = opa & opb;
      default:        core_v = opb;
    endcase
  end

  always_comb begin
    case (shift)
      SH_LSR:  {result, carry_out} = {1'b0, core_v};
      SH_ASR:  {result, carry_out} = {core_v[W-1], core_v};
      default: {result, carry_out} = {core_v, core_c};
    endcase
  end

  assign zero_out = ~|result;

  logic plain_sh;
  assign plain_sh = (shift != SH_LSR) && (shift != SH_ASR);

  always_comb begin
    if (shift == SH_LSR)
      a_r6_msb_clear: assert (result[W-1] == 1'b0);
    if (shift == SH_ASR)
      a_r7_sign_kept: assert (result[W-1] == result[W-2]);
    if (plain_sh && (op == OP_PASA))
      a_r4_pass_primary: assert (result == opa && !carry_out);
    if (plain_sh && (op == OP_PASB))
      a_r4_pass_secondary: assert (result == opb && !carry_out);
    if (plain_sh && (op == OP_ADD))
      a_r1_sum: assert ((int'(opa) + int'(opb)) == (int'(result) + (carry_out ? (1 << W) : 0)));
    if (plain_sh && (op == OP_SBB))
      a_r3_borrow: assert (carry_out == (int'(opa) < int'(opb) + int'(carry_in)));
    if (plain_sh && (op == OP_XOR || op == OP_OR || op == OP_AND))
      a_r5_logic_nocarry: assert (!carry_out);
    a_r9_zero: assert (zero_out == (result == '0));
  end

endmodule

// File: tb/tb_alu8_shift.sv
module tb_alu8_shift;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] opa, opb, result;
  logic [2:0] op;
  logic [1:0] shift;
  logic carry_in, carry_out, zero_out;

  alu8_shift dut (
    .opa(opa), .opb(opb), .op(op), .shift(shift), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .zero_out(zero_out)
  );

  typedef struct {
    logic [7:0] r;
    logic c;
    logic z;
    string tag;
  } exp_t;

  exp_t sb[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  bit reported = 0;

  task automatic drive(input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] o, input logic [1:0] s, input logic ci);
    int ia, ib, v;
    int c;
    exp_t e;
    ia = a; ib = b; c = 0;
    case (o)
      3'd0: begin v = ia + ib; c = (v > 255); end
      3'd1: begin v = ia + ib + ci; c = (v > 255); end
      3'd2: begin v = ia - ib - ci; c = (ia < ib + ci); end
      3'd3: v = ia;
      3'd4: v = ia ^ ib;
      3'd5: v = ia | ib;
      3'd6: v = ia & ib;
      default: v = ib;
    endcase
    v = v & 255;
    case (o)
      3'd0: e.tag = "R1";
      3'd1: e.tag = "R2";
      3'd2: e.tag = "R3";
      3'd3, 3'd7: e.tag = "R4";
      default: e.tag = "R5";
    endcase
    if (s == 2'b01) begin
      c = v % 2; v = v / 2; e.tag = "R6";
    end else if (s == 2'b10) begin
      c = v % 2; v = (v / 2) + (v >= 128 ? 128 : 0); e.tag = "R7";
    end else if (s == 2'b11) begin
      e.tag = "R8";
    end
    e.r = v[7:0];
    e.c = c[0];
    e.z = (v == 0);
    if (v == 0) e.tag = {e.tag, "/R9"};
    @(negedge clk);
    opa = a; opb = b; op = o; shift = s; carry_in = ci;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        n_vec++;
        if (result !== e.r || carry_out !== e.c || zero_out !== e.z) begin
          n_bad++;
          $display("FAIL %s: got r=%h c=%b z=%b, expected r=%h c=%b z=%b",
                   e.tag, result, carry_out, zero_out, e.r, e.c, e.z);
        end
      end
    end
  end

  task automatic finish_up();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung, expected completion");
      finish_up();
    end
  end

  initial begin : driver
    opa = 0; opb = 0; op = 0; shift = 0; carry_in = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R1 / R9: wrap to zero with carry; no-wrap case
    drive(8'h80, 8'h80, 3'd0, 2'b00, 1'b1);
    drive(8'h12, 8'h34, 3'd0, 2'b00, 1'b1);
    // R2: carry added, carry ignored when clear
    drive(8'hFF, 8'h00, 3'd1, 2'b00, 1'b1);
    drive(8'h7F, 8'h80, 3'd1, 2'b00, 1'b0);
    // R3: borrow on sum of operand and carry
    drive(8'h00, 8'h00, 3'd2, 2'b00, 1'b1);
    drive(8'h55, 8'hFF, 3'd2, 2'b00, 1'b1);
    drive(8'h10, 8'h0F, 3'd2, 2'b00, 1'b1);
    drive(8'h10, 8'h10, 3'd2, 2'b00, 1'b0);
    // R4: pass-throughs, carry_in ignored
    drive(8'hA5, 8'h3C, 3'd3, 2'b00, 1'b1);
    drive(8'hA5, 8'h3C, 3'd7, 2'b00, 1'b1);
    // R5: logic
    drive(8'hF0, 8'hFF, 3'd4, 2'b00, 1'b1);
    drive(8'hF0, 8'h0F, 3'd5, 2'b00, 1'b1);
    drive(8'hF0, 8'h0F, 3'd6, 2'b00, 1'b1);
    // R6 / R7: shifts with sign bit set and odd values
    drive(8'h81, 8'h00, 3'd3, 2'b01, 1'b0);
    drive(8'h81, 8'h00, 3'd3, 2'b10, 1'b0);
    drive(8'hFF, 8'h01, 3'd0, 2'b01, 1'b0);
    drive(8'h01, 8'h00, 3'd7, 2'b10, 1'b0);
    // R8: code 11 keeps carry
    drive(8'hFF, 8'h03, 3'd0, 2'b11, 1'b0);
    for (int i = 0; i < 2000; i++)
      drive(8'($urandom), 8'($urandom), 3'(i % 8), 2'((i / 8) % 4), 1'($urandom));
    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    finish_up();
  end
endmodule